// File: doc/BRIEF.md
# Sliding-Window Address Uniqueness Checker

This block sits beside a valid/address handshake, such as the address channel of an AXI-style bus, and flags any accepted address that repeats one seen among the recent accepted beats. An address counts as accepted on every rising clock edge where `valid_i` is high. The block keeps a shift-register history of the previous `DEPTH` accepted addresses of the current burst. Each slot of the history has its own occupancy bit. Every new address is compared against all occupied slots in the same cycle.

A match produces a registered one-cycle error pulse on the next edge. The pulse comes with the index of the matching slot. Slot k holds the address accepted k+1 beats earlier. When `valid_i` rises from low to high, the block treats this as the start of a fresh burst: it discards the whole history and starts checking again from that beat. A saturating fill counter shows how many slots are occupied, so an observer can tell when the window is full.

Top module: `addr_uniq_checker`

## Requirements
- R1: A cycle with `valid_i` low is ignored: it produces no error and leaves the fill count and the history unchanged.
- R2: An accepted beat whose address equals an occupied history slot raises `dup_err_o` for exactly one cycle, on the clock edge that accepts it.
- R3: While `dup_err_o` is high, `dup_idx_o` gives the slot that matched. Slot k holds the address accepted k+1 beats earlier. If several slots match, the lowest index wins. While `dup_err_o` is low, `dup_idx_o` is 0.
- R4: Addresses that are distinct from every occupied slot give no error. Empty slots never match, including the all-zero address after reset.
- R5: The window spans the previous `DEPTH` (16) accepted beats. A repeat with 15 other beats in between is flagged with index 15. A repeat with 16 other beats in between is legal.
- R6: A beat that is flagged as a duplicate is still pushed into the history.
- R7: A beat where `valid_i` is high after a low cycle (or after reset) starts a burst. That beat is never flagged, and afterwards the history holds only that beat, so `fill_o` becomes 1.
- R8: `fill_o` counts the accepted beats of the current burst and saturates at `DEPTH`.
- R9: Synchronous active-high reset clears `dup_err_o`, `dup_idx_o` and `fill_o` to 0 and empties the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Beat qualifier; the address is accepted when this is high |
| addr_i | input | 32 | Address of the current beat |
| dup_err_o | output | 1 | One-cycle duplicate pulse, registered |
| dup_idx_o | output | 4 | Index of the matching slot (0 = previous beat) |
| fill_o | output | 5 | Occupied history slots, 0 to 16 |

## Verification
The bench builds the block with its defaults: a 32-bit address and a window of 16 slots. With these values the window edge can be reached directly. One case repeats an address after 15 other beats and must see index 15. Another repeats it after 16 other beats and must see no error. Random addresses are drawn from a pool of 24 values, so repeats fall both inside and just outside the window. Random valid gaps keep restarting bursts, which exercises the clear on a rising valid against a history that holds stale matches.

// File: rtl/addr_uniq_pkg.sv
package addr_uniq_pkg;
    localparam int unsigned DEF_ADDR_W = 32;
    localparam int unsigned DEF_DEPTH  = 16;
endpackage

// File: rtl/uniq_history.sv
module uniq_history #(
    parameter int unsigned AW    = addr_uniq_pkg::DEF_ADDR_W,
    parameter int unsigned DEPTH = addr_uniq_pkg::DEF_DEPTH
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      push,
    input  logic                      restart,
    input  logic [AW-1:0]             addr,
    output logic [DEPTH-1:0][AW-1:0]  slot_o,
    output logic [DEPTH-1:0]          occ_o
);
    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] slot;
        logic [DEPTH-1:0]         occ;
    } hist_st_t;

    hist_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.slot[0] = addr;
            st_d.occ[0]  = 1'b1;
            for (int i = 1; i < int'(DEPTH); i++) begin
                st_d.slot[i] = st_q.slot[i-1];
                st_d.occ[i]  = restart ? 1'b0 : st_q.occ[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_o = st_q.slot;
    assign occ_o  = st_q.occ;

    // Occupied slots always form a contiguous run from slot 0 (R8 fill shape)
    assert_occ_contiguous_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q.occ & (st_q.occ + {{(DEPTH-1){1'b0}}, 1'b1})) == '0);

    // A burst start leaves exactly one occupied slot (R7)
    assert_restart_single_R7: assert property (@(posedge clk) disable iff (rst)
        (push && restart) |=> (st_q.occ == {{(DEPTH-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/uniq_match.sv
module uniq_match #(
    parameter int unsigned AW    = addr_uniq_pkg::DEF_ADDR_W,
    parameter int unsigned DEPTH = addr_uniq_pkg::DEF_DEPTH
) (
    input  logic [DEPTH-1:0][AW-1:0] slot,
    input  logic [DEPTH-1:0]         occ,
    input  logic [AW-1:0]            addr,
    output logic [DEPTH-1:0]         hit
);
    for (genvar g = 0; g < int'(DEPTH); g++) begin : g_cmp
        assign hit[g] = occ[g] && (slot[g] == addr);
    end
endmodule

// File: rtl/uniq_encode.sv
module uniq_encode #(
    parameter int unsigned DEPTH = addr_uniq_pkg::DEF_DEPTH,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] hit,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |hit;
        idx = '0;
        for (int i = int'(DEPTH) - 1; i >= 0; i--) begin
            if (hit[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/addr_uniq_checker.sv
module addr_uniq_checker #(
    parameter int unsigned AW    = addr_uniq_pkg::DEF_ADDR_W,
    parameter int unsigned DEPTH = addr_uniq_pkg::DEF_DEPTH,
    localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [AW-1:0]     addr_i,
    output logic              dup_err_o,
    output logic [IDX_W-1:0]  dup_idx_o,
    output logic [FILL_W-1:0] fill_o
);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(DEPTH);

    typedef struct packed {
        logic              vprev;
        logic              err;
        logic [IDX_W-1:0]  idx;
        logic [FILL_W-1:0] fill;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [DEPTH-1:0][AW-1:0] slot_w;
    logic [DEPTH-1:0]         occ_w;
    logic [DEPTH-1:0]         hit_w;
    logic                     any_w;
    logic [IDX_W-1:0]         enc_w;
    logic                     start_w;

    assign start_w = valid_i && !st_q.vprev;

    uniq_history #(.AW(AW), .DEPTH(DEPTH)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .push    (valid_i),
        .restart (start_w),
        .addr    (addr_i),
        .slot_o  (slot_w),
        .occ_o   (occ_w)
    );

    uniq_match #(.AW(AW), .DEPTH(DEPTH)) u_match (
        .slot (slot_w),
        .occ  (occ_w),
        .addr (addr_i),
        .hit  (hit_w)
    );

    uniq_encode #(.DEPTH(DEPTH)) u_enc (
        .hit (hit_w),
        .any (any_w),
        .idx (enc_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.vprev = valid_i;
        st_d.err   = 1'b0;
        st_d.idx   = '0;
        if (valid_i) begin
            if (start_w) begin
                st_d.fill = FILL_W'(1);
            end else begin
                st_d.err = any_w;
                st_d.idx = any_w ? enc_w : '0;
                if (st_q.fill != FILL_MAX) begin
                    st_d.fill = st_q.fill + FILL_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dup_err_o = st_q.err;
    assign dup_idx_o = st_q.idx;
    assign fill_o    = st_q.fill;

    // An error only follows an accepted, non-starting beat (R1, R7)
    assert_err_after_accept_R1: assert property (@(posedge clk) disable iff (rst)
        dup_err_o |-> ($past(valid_i) && $past(st_q.vprev)));

    // Reported index points at a slot that really matched (R3)
    assert_idx_hits_R3: assert property (@(posedge clk) disable iff (rst)
        any_w |-> hit_w[enc_w]);

    // Fill count agrees with the history's occupancy bits (R8)
    assert_fill_matches_occ_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(occ_w) == int'(fill_o));

    // Saturated window stays full on further beats (R8)
    assert_fill_saturates_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && st_q.vprev && fill_o == FILL_MAX) |=> (fill_o == FILL_MAX));

    // Burst start is never flagged and leaves one entry (R7)
    assert_start_clean_R7: assert property (@(posedge clk) disable iff (rst)
        start_w |=> (!dup_err_o && fill_o == FILL_W'(1)));

    // Idle cycles leave the fill count unchanged (R1)
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(fill_o) && !dup_err_o));
endmodule

// File: tb/sim_addr_uniq_checker.sv
module sim_addr_uniq_checker;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic        dup_err_o;
    logic [3:0]  dup_idx_o;
    logic [4:0]  fill_o;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    logic [31:0] m_slot [DEPTH];
    int          m_n = 0;
    bit          m_vprev = 1'b0;

    always #10 clk = ~clk;

    addr_uniq_checker u0 (
        .clk(clk), .rst(rst), .valid_i(valid_i), .addr_i(addr_i),
        .dup_err_o(dup_err_o), .dup_idx_o(dup_idx_o), .fill_o(fill_o)
    );

    // Index of the most recent matching slot, or -1
    function automatic int find_match(logic [31:0] a);
        for (int k = 0; k < m_n; k++) begin
            if (m_slot[k] == a) return k;
        end
        return -1;
    endfunction

    task automatic check(string tag, bit e_err, int e_idx, int e_fill);
        nvec++;
        if (dup_err_o !== e_err || int'(dup_idx_o) != e_idx || int'(fill_o) != e_fill) begin
            nbad++;
            $display("FAIL %s: err/idx/fill actual %0b/%0d/%0d expected %0b/%0d/%0d",
                     tag, dup_err_o, dup_idx_o, fill_o, e_err, e_idx, e_fill);
        end
    endtask

    task automatic step(bit v, logic [31:0] a, string tag);
        bit e_err = 1'b0;
        int e_idx = 0;
        int k;
        valid_i = v;
        addr_i  = a;
        if (v) begin
            if (!m_vprev) begin
                m_n = 1;
                m_slot[0] = a;
            end else begin
                k = find_match(a);
                if (k >= 0) begin
                    e_err = 1'b1;
                    e_idx = k;
                end
                for (int i = DEPTH - 1; i > 0; i--) m_slot[i] = m_slot[i-1];
                m_slot[0] = a;
                if (m_n < DEPTH) m_n++;
            end
        end
        m_vprev = v;
        @(posedge clk);
        @(negedge clk);
        check(tag, e_err, e_idx, m_n);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R9 reset", 1'b0, 0, 0);
        rst = 1'b0;

        // R4: zero address into an empty history is not a match
        step(1, 32'h0, "R4 empty");
        step(1, 32'h5, "R4 distinct");
        step(1, 32'h0, "R2 dup idx1");
        step(1, 32'h0, "R6 dup pushed idx0");
        step(1, 32'h5, "R3 lowest idx");
        step(0, 32'h5, "R1 idle ignored");
        step(0, 32'h0, "R1 idle ignored");
        // R7: restart clears the stale 0x5
        step(1, 32'h5, "R7 restart");
        step(1, 32'h9, "R7 fresh");

        // R5: window edge, repeat after 15 others then after 16 others
        step(0, 0, "R1 gap");
        step(1, 32'hA000, "R5 start");
        for (int i = 1; i < DEPTH; i++) step(1, 32'hB000 + i, "R8 fill");
        step(1, 32'hA000, "R5 edge idx15");
        step(1, 32'hC000, "R8 saturate");
        step(0, 0, "R1 gap");
        step(1, 32'hA100, "R5 start");
        for (int i = 1; i <= DEPTH; i++) step(1, 32'hD000 + i, "R8 saturate");
        step(1, 32'hA100, "R5 beyond window");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            step(($urandom_range(0, 9) < 8), $urandom_range(0, 23), "R2 random");
        end

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_n = 0;
        m_vprev = 1'b0;
        check("R9 reset again", 1'b0, 0, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule